// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller whose pins are grouped in banks of 32. Every bank owns a register window of 0x200 bytes. A single-cycle register bus carries writes and reads. Through it, software sets the output value, output enable and pull configuration of each pin, and reads the synchronized pad input. The controller drives the pad-side output, output-enable, pull-enable and pull-select vectors directly from its registers.

Each pin has its own interrupt detector. Three configuration bits pick the trigger: level or edge, dual edge, and polarity. A detected event latches into a raw status bit. A mask gates that bit into a masked status bit. Software acknowledges a pin by writing a one to the clear register, and a single interrupt line reports any masked status bit of any bank.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset every writable register is 0, so `pad_oe`, `pad_out`, `pull_en`, `pull_up` and `irq` are all 0 and raw status reads 0.
- R2: Byte address = bank × 0x200 + offset. Pin p lives in bank p/32 at bit p%32. A write to one bank leaves the registers of every other bank unchanged.
- R3: Offset 0x04 (data out) drives `pad_out` and offset 0x08 (output enable, 1 = drive) drives `pad_oe` for the bank's 32 pins. Both read back what was written.
- R4: Offset 0x00 returns `pad_in` after a two-flop synchronizer. It is read-only, and writes to it change nothing.
- R5: Offset 0x38 (pull enable, 1 = on) drives `pull_en`. Offset 0x34 (pull select, 1 = up, 0 = down) drives `pull_up`.
- R6: With offset 0x0C bit = 0 (edge) and offset 0x10 bit = 0, a rising edge latches raw status (offset 0x1C) when the offset 0x14 polarity bit is 1, and a falling edge latches it when that bit is 0. Latched status stays set until cleared.
- R7: With offset 0x10 bit = 1 in edge mode, both rising and falling edges latch raw status.
- R8: With offset 0x0C bit = 1 (level), raw status is set in every cycle in which the pin is at its active level (high if polarity is 1, low if 0). A clear therefore does not remove it while the level persists.
- R9: Offset 0x18 bit = 1 unmasks the pin. Offset 0x20 reads raw status AND mask.
- R10: Writing offset 0x24 clears the raw status bits written as 1. Bits written as 0 are unaffected, and writes to offsets 0x1C and 0x20 are ignored.
- R11: When a clear and a new event for the same pin fall in the same cycle, the status bit ends up set.
- R12: `irq` is 1 exactly when some masked status bit of some bank is 1.
- R13: Reads of unmapped offsets, and of the write-only clear offset, return 0. Read data appears on `bus_rdata` one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address: bank index above bit 9, offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_BANKS×32 (64) | Asynchronous pad inputs |
| pad_out | output | NUM_BANKS×32 (64) | Pad output values |
| pad_oe | output | NUM_BANKS×32 (64) | Pad output enables |
| pull_en | output | NUM_BANKS×32 (64) | Pull resistor enables |
| pull_up | output | NUM_BANKS×32 (64) | Pull direction, 1 = up |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same status bit in one cycle: the write-one-to-clear acknowledge and a fresh edge detection. The bench arms a pin for dual-edge detection and lets a first edge latch its status. It then toggles the pad and issues the clear write at the exact posedge on which the second edge, now two synchronizer stages later, reaches the status register. The bench judges the outcome by reading raw status, which must still be 1. A plain clear afterwards must read 0, which confirms that the earlier result was not a clear that never took effect.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

   localparam int BANK_PINS   = 32;
   localparam int OFS_W       = 9;   // bank window of 0x200 bytes

   typedef enum logic [3:0] {
      RS_NONE,
      RS_DIN,
      RS_DOUT,
      RS_OE,
      RS_TRIG,
      RS_BOTH,
      RS_POL,
      RS_MASK,
      RS_RAW,
      RS_MSTAT,
      RS_CLR,
      RS_PSEL,
      RS_PEN
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
      case (ofs)
         9'h000:  return RS_DIN;
         9'h004:  return RS_DOUT;
         9'h008:  return RS_OE;
         9'h00C:  return RS_TRIG;
         9'h010:  return RS_BOTH;
         9'h014:  return RS_POL;
         9'h018:  return RS_MASK;
         9'h01C:  return RS_RAW;
         9'h020:  return RS_MSTAT;
         9'h024:  return RS_CLR;
         9'h034:  return RS_PSEL;
         9'h038:  return RS_PEN;
         default: return RS_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pbc_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("pbc_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[gi] <= '0;
            end else begin
               if (gi == 0) begin
                  stage_q[gi] <= d;
               end else begin
                  stage_q[gi] <= stage_q[(gi > 0) ? gi - 1 : 0];
               end
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pbc_pin_detect.sv
module pbc_pin_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic lvl_mode,
   input  logic both,
   input  logic pol,
   output logic hit
);

   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= cur;
      end
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

   always_comb begin
      if (lvl_mode) begin
         hit = pol ? cur : ~cur;
      end else if (both) begin
         hit = rise | fall;
      end else begin
         hit = pol ? rise : fall;
      end
   end

endmodule

// File: rtl/pbc_bank.sv
module pbc_bank
   import pbc_pkg::*;
#(
   parameter int PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  reg_sel_e        rsel,
   input  logic [31:0]     wdata,
   input  logic [PINS-1:0] pin_sync,
   output logic [31:0]     rd_word,
   output logic [PINS-1:0] dout,
   output logic [PINS-1:0] oe,
   output logic [PINS-1:0] psel,
   output logic [PINS-1:0] pen,
   output logic            masked_any
);

   generate
      if (PINS != 32) begin : g_bad_pins
         $error("pbc_bank holds exactly 32 pins");
      end
   endgenerate

   logic [PINS-1:0] trig_q, both_q, pol_q, mask_q, status_q;
   logic [PINS-1:0] set_vec;
   logic [PINS-1:0] clr_vec;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout   <= '0;
         oe     <= '0;
         trig_q <= '0;
         both_q <= '0;
         pol_q  <= '0;
         mask_q <= '0;
         psel   <= '0;
         pen    <= '0;
      end else if (wr_en) begin
         case (rsel)
            RS_DOUT: dout   <= wdata[PINS-1:0];
            RS_OE:   oe     <= wdata[PINS-1:0];
            RS_TRIG: trig_q <= wdata[PINS-1:0];
            RS_BOTH: both_q <= wdata[PINS-1:0];
            RS_POL:  pol_q  <= wdata[PINS-1:0];
            RS_MASK: mask_q <= wdata[PINS-1:0];
            RS_PSEL: psel   <= wdata[PINS-1:0];
            RS_PEN:  pen    <= wdata[PINS-1:0];
            default: ;
         endcase
      end
   end

   // per-pin event detection
   genvar gp;
   generate
      for (gp = 0; gp < PINS; gp++) begin : g_pin
         pbc_pin_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur      (pin_sync[gp]),
            .lvl_mode (trig_q[gp]),
            .both     (both_q[gp]),
            .pol      (pol_q[gp]),
            .hit      (set_vec[gp])
         );
      end
   endgenerate

   assign clr_vec = (wr_en && rsel == RS_CLR) ? wdata[PINS-1:0] : '0;

   // a new event overrides a simultaneous acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      rd_word = '0;
      case (rsel)
         RS_DIN:   rd_word[PINS-1:0] = pin_sync;
         RS_DOUT:  rd_word[PINS-1:0] = dout;
         RS_OE:    rd_word[PINS-1:0] = oe;
         RS_TRIG:  rd_word[PINS-1:0] = trig_q;
         RS_BOTH:  rd_word[PINS-1:0] = both_q;
         RS_POL:   rd_word[PINS-1:0] = pol_q;
         RS_MASK:  rd_word[PINS-1:0] = mask_q;
         RS_RAW:   rd_word[PINS-1:0] = status_q;
         RS_MSTAT: rd_word[PINS-1:0] = status_q & mask_q;
         RS_PSEL:  rd_word[PINS-1:0] = psel;
         RS_PEN:   rd_word[PINS-1:0] = pen;
         default:  rd_word = '0;
      endcase
   end

   assign masked_any = |(status_q & mask_q);

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0)); // R10

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R11

   AST_STATUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0)); // R6

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rsel == RS_OE) |=> $stable(oe)); // R3

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
   import pbc_pkg::*;
#(
   parameter int  NUM_BANKS   = 2,
   parameter int  SYNC_STAGES = 2,
   localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W      = OFS_W + BANK_W,
   localparam int NPINS       = NUM_BANKS * BANK_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pull_en,
   output logic [NPINS-1:0]  pull_up,
   output logic              irq
);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("pin_bank_ctrl needs at least one bank");
      end
   endgenerate

   logic [NPINS-1:0]  pin_sync;
   reg_sel_e          rsel;
   logic [BANK_W-1:0] bank_idx;
   logic              bank_ok;
   logic              rd_hit;
   logic              rd_req;
   logic [31:0]       bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;
   logic [31:0]       rd_mux;

   assign rsel     = decode_ofs(bus_addr[OFS_W-1:0]);
   assign bank_idx = bus_addr[ADDR_W-1:OFS_W];
   assign bank_ok  = (32'(bank_idx) < NUM_BANKS);
   assign rd_req   = bus_sel && !bus_wr;
   assign rd_hit   = bank_ok && (rsel != RS_NONE) && (rsel != RS_CLR);

   pbc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   genvar gb;
   generate
      for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
         logic wr_this;
         assign wr_this = bus_sel && bus_wr && (32'(bank_idx) == gb);

         pbc_bank #(.PINS(BANK_PINS)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_this),
            .rsel       (rsel),
            .wdata      (bus_wdata),
            .pin_sync   (pin_sync[gb*BANK_PINS +: BANK_PINS]),
            .rd_word    (bank_rd[gb]),
            .dout       (pad_out[gb*BANK_PINS +: BANK_PINS]),
            .oe         (pad_oe[gb*BANK_PINS +: BANK_PINS]),
            .psel       (pull_up[gb*BANK_PINS +: BANK_PINS]),
            .pen        (pull_en[gb*BANK_PINS +: BANK_PINS]),
            .masked_any (bank_irq[gb])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_hit && 32'(bank_idx) == b) begin
            rd_mux = bank_rd[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         bus_rdata <= rd_mux;
      end
   end

   assign irq = |bank_irq;

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_hit) |=> (bus_rdata == '0)); // R13

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_irq == '0) |-> !irq); // R12

endmodule

// File: tb/pin_bank_ctrl_bench.sv
module pin_bank_ctrl_bench;

   localparam int NB = 2;
   localparam int NP = NB * 32;
   localparam int AW = 10;

   localparam logic [8:0] A_DIN = 9'h000, A_DOUT = 9'h004, A_OE = 9'h008,
      A_TRIG = 9'h00C, A_BOTH = 9'h010, A_POL = 9'h014, A_MASK = 9'h018,
      A_RAW = 9'h01C, A_MST = 9'h020, A_CLR = 9'h024, A_PSEL = 9'h034,
      A_PEN = 9'h038;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pull_en, pull_up;
   logic          irq;

   int n_vec = 0;
   int n_miss = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sb_q[$];
   logic mon_armed = 1'b0;

   always #5 clk = ~clk;

   pin_bank_ctrl #(.NUM_BANKS(NB)) u_pin_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
   );

   function automatic logic [AW-1:0] ra(input int bank, input logic [8:0] ofs);
      return AW'(bank * 32'h200) | AW'(ofs);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor side of the scoreboard
   always @(posedge clk) mon_armed <= bus_sel && !bus_wr;

   always @(negedge clk) begin
      if (mon_armed) begin
         if (sb_q.size() == 0) begin
            n_vec++;
            n_miss++;
            $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, 64'(bus_rdata), 64'(e.exp));
         end
      end
   end

   // driver tasks
   task automatic bus_write(input int bank, input logic [8:0] ofs, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ra(bank, ofs); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int bank, input logic [8:0] ofs, input logic [31:0] exp,
                           input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ra(bank, ofs);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 pad_oe", pad_oe, '0);
      check("R1 pad_out", pad_out, '0);
      check("R1 pull_en", pull_en, '0);
      check("R1 irq", 64'(irq), 64'h0);
      bus_read(0, A_MASK, 32'h0, "R1 mask");
      bus_read(1, A_RAW, 32'h0, "R1 raw");

      // R3 / R2: outputs and bank addressing
      bus_write(0, A_DOUT, 32'hA5A5_0F0F);
      bus_write(0, A_OE, 32'hFFFF_0000);
      @(negedge clk);
      check("R3 pad_out", pad_out, 64'h0000_0000_A5A5_0F0F);
      check("R3 pad_oe", pad_oe, 64'h0000_0000_FFFF_0000);
      bus_read(0, A_OE, 32'hFFFF_0000, "R3 oe readback");
      bus_write(1, A_DOUT, 32'h1234_5678);
      @(negedge clk);
      check("R2 bank1 out", pad_out, 64'h1234_5678_A5A5_0F0F);
      bus_read(0, A_DOUT, 32'hA5A5_0F0F, "R2 bank0 kept");

      // R5: pull controls
      bus_write(1, A_PEN, 32'h0000_00FF);
      bus_write(1, A_PSEL, 32'h0000_000F);
      @(negedge clk);
      check("R5 pull_en", pull_en, 64'h0000_00FF_0000_0000);
      check("R5 pull_up", pull_up, 64'h0000_000F_0000_0000);

      // R4: synchronized input, read-only
      pad_in = 64'hC3C3_0001_8000_7E00;
      settle();
      bus_read(0, A_DIN, 32'h8000_7E00, "R4 din bank0");
      bus_read(1, A_DIN, 32'hC3C3_0001, "R4 din bank1");
      bus_write(0, A_DIN, 32'h0000_FFFF);
      bus_read(0, A_DIN, 32'h8000_7E00, "R4 din write ignored");
      pad_in = '0;
      settle();
      bus_write(0, A_CLR, 32'hFFFF_FFFF);
      bus_write(1, A_CLR, 32'hFFFF_FFFF);
      bus_read(0, A_RAW, 32'h0, "R10 clear all bank0");

      // R6: single edge, both polarities
      bus_write(0, A_POL, 32'h0000_0008);
      @(negedge clk);
      pad_in[3] = 1'b1; pad_in[5] = 1'b1;
      settle();
      bus_read(0, A_RAW, 32'h0000_0008, "R6 rising only");
      pad_in[5] = 1'b0;
      settle();
      bus_read(0, A_RAW, 32'h0000_0028, "R6 falling latched");
      pad_in[3] = 1'b0;
      settle();
      bus_read(0, A_RAW, 32'h0000_0028, "R6 sticky");

      // R9 / R12 / R10
      bus_write(0, A_MASK, 32'h0000_0020);
      bus_read(0, A_MST, 32'h0000_0020, "R9 masked status");
      check("R12 irq set", 64'(irq), 64'h1);
      bus_write(0, A_CLR, 32'h0000_0008);
      bus_read(0, A_RAW, 32'h0000_0020, "R10 zero bits untouched");
      bus_write(0, A_RAW, 32'h0000_0000);
      bus_read(0, A_RAW, 32'h0000_0020, "R10 raw write ignored");
      bus_write(0, A_CLR, 32'h0000_0020);
      bus_read(0, A_RAW, 32'h0000_0000, "R10 cleared");
      check("R12 irq clear", 64'(irq), 64'h0);

      // R7: dual edge on pin 0
      bus_write(0, A_BOTH, 32'h0000_0001);
      @(negedge clk);
      pad_in[0] = 1'b1;
      settle();
      bus_read(0, A_RAW, 32'h0000_0001, "R7 rise");
      bus_write(0, A_CLR, 32'h0000_0001);
      pad_in[0] = 1'b0;
      settle();
      bus_read(0, A_RAW, 32'h0000_0001, "R7 fall");

      // R11: clear lands on the cycle of a new edge
      @(negedge clk);
      pad_in[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      bus_write(0, A_CLR, 32'h0000_0001);
      bus_read(0, A_RAW, 32'h0000_0001, "R11 event wins");
      bus_write(0, A_CLR, 32'h0000_0001);
      bus_read(0, A_RAW, 32'h0000_0000, "R11 plain clear");

      // R8: level mode on pin 39 (bank 1 bit 7)
      bus_write(1, A_POL, 32'h0000_0080);
      bus_write(1, A_TRIG, 32'h0000_0080);
      bus_write(1, A_CLR, 32'hFFFF_FFFF);
      bus_read(1, A_RAW, 32'h0000_0000, "R8 idle level");
      pad_in[39] = 1'b1;
      settle();
      bus_read(1, A_RAW, 32'h0000_0080, "R8 level set");
      bus_write(1, A_MASK, 32'h0000_0080);
      @(negedge clk);
      check("R12 irq from bank1", 64'(irq), 64'h1);
      bus_write(1, A_CLR, 32'h0000_0080);
      bus_read(1, A_RAW, 32'h0000_0080, "R8 reasserts");
      pad_in[39] = 1'b0;
      settle();
      bus_write(1, A_CLR, 32'h0000_0080);
      bus_read(1, A_RAW, 32'h0000_0000, "R8 released");
      check("R12 irq low", 64'(irq), 64'h0);

      // R13: unmapped and write-only offsets
      bus_read(0, 9'h028, 32'h0, "R13 gap 0x28");
      bus_read(1, 9'h030, 32'h0, "R13 gap 0x30");
      bus_read(0, A_CLR, 32'h0, "R13 clear reads 0");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         check("scoreboard drained", 64'(sb_q.size()), 64'h0);
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_vec++;
            n_miss++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule